// File: doc/BRIEF.md
# SDRAM Command Sequencer with Refresh Scheduling

This block sits between a simple single-access request port and a two-bank synchronous DRAM with 11 row bits and 9 column bits. After reset it holds the command bus quiet for a timed pause. It then closes both banks and issues two auto refreshes. Last in that sequence, it writes the mode word. From then on it serves one read or one write per request. Each access is an ACTIVE followed by a READ or WRITE with auto precharge. Between accesses it fits in periodic auto refresh commands.

Every timing constraint is a clock-count parameter, and the block derives the spacing between commands from these parameters. It drives the chip-select, row-strobe, column-strobe and write-enable lines, the bank bit, the address bus and the byte masks. It leaves write-data steering and read-data capture to a separate data path. It asserts `ack` in the cycle the column command leaves the block. That cycle is the one from which such a data path can count.

Top module: `sdram_seq`

## Requirements
- R1: While reset is held, chip select is high (inhibit), every DQM bit is high and `ack` is low.
- R2: After reset release, no command other than inhibit or NOP appears for at least T_PAUSE cycles. The first command is then PRECHARGE with A10 high, which closes both banks.
- R3: The first REFRESH follows the precharge-all by exactly T_RP cycles. A second REFRESH follows by exactly T_RC cycles, and LOAD MODE follows by another T_RC. The mode word on {BA0, A[10:0]} has burst length code in bits 2:0, burst type in bit 3, CAS latency in bits 6:4, single-location writes in bit 9, and zeros elsewhere. With the defaults the word is 12'h230.
- R4: The command codes on {CS#, RAS#, CAS#, WE#} are as follows: LOAD MODE 0000, REFRESH 0001, PRECHARGE 0010, ACTIVE 0011, WRITE 0100, READ 0101, NOP 0111, and 1111 for inhibit.
- R5: The request address is {bank, row[10:0], col[8:0]}. ACTIVE carries the row on A and the bank on BA0. The READ or WRITE follows after exactly T_RCD cycles, with the column on A[8:0], A10 high, A9 low and the same bank.
- R6: With a request pending, the next ACTIVE comes exactly max(T_RC, T_RAS+T_RP) cycles after the previous one for a read. For a write the term T_RCD+T_WR+T_RP also enters the maximum.
- R7: With no user traffic, REFRESH commands are spaced exactly T_REFI cycles apart.
- R8: When a refresh is due, it is issued before a waiting user request once the access in flight has finished.
- R9: In the WRITE cycle, DQM equals the mask given with the request. In every other cycle outside the read window, DQM is all ones.
- R10: For a read with CAS latency 3, DQM is all zeros in exactly the cycle after READ. With latency 2, DQM is all zeros in the READ cycle itself.
- R11: `ack` is high for exactly the cycles in which READ or WRITE is on the bus.
- R12: After any REFRESH, the next ACTIVE or REFRESH waits at least T_RC cycles. After LOAD MODE, the next ACTIVE or REFRESH waits at least T_MRD cycles. An ACTIVE that follows a REFRESH with a request already waiting appears exactly T_RC cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and memory clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req | input | 1 | Access request, held until `ack` |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | {bank, row[10:0], col[8:0]} |
| req_wmask | input | 2 | Byte mask for the write (1 = masked) |
| ack | output | 1 | Pulse marking the column command of the accepted request |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 1 | Bank select |
| sd_a | output | 11 | Row, column or mode word; A10 selects auto precharge or all-bank precharge |
| sd_dqm | output | 2 | Byte mask / output enable, active high |

## Verification
The built-in checks assume several things about the inputs. The requester holds `req`, `req_we`, `req_addr` and `req_wmask` steady from assertion until `ack`. CAS_LAT is 2 or 3. Every timing parameter is at least one cycle. The directed stimulus keeps to this: each scenario changes request fields only at the falling edge of an `ack` cycle, or while `req` is low. The scenarios also line requests up against the refresh cadence, which sets up both the idle refresh period and the collision between a due refresh and a waiting request.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LMR = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_BST = 4'b0110,
    CMD_NOP = 4'b0111,
    CMD_INH = 4'b1111
  } sd_cmd_e;

  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_INIT_REF,
    ST_INIT_LMR,
    ST_IDLE,
    ST_RW
  } seq_state_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic [11:0] mode_word(input logic [2:0] bl_code,
                                            input logic       interleave,
                                            input logic [2:0] cl,
                                            input logic       single_wr);
    return {2'b00, single_wr, 2'b00, cl, interleave, bl_code};
  endfunction

endpackage

// File: rtl/sdc_delay.sv
module sdc_delay #(
  parameter int            W       = 8,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic         done
);
  logic [W-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (ld)                cnt_n = ld_val;
    else if (cnt_q != '0)  cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= RST_VAL;
    else        cnt_q <= cnt_n;
  end

  assign done = (cnt_q == '0);

  // R6: a running wait never jumps ahead; it only drops by one per cycle
  a_r6_wait_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sdc_ref_tick.sv
module sdc_ref_tick #(
  parameter int T_REFI = 1560,
  localparam int W = $clog2(T_REFI + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clr,
  output logic pend
);
  logic [W-1:0] cnt_q, cnt_n;
  logic         pend_q, pend_n;
  logic         tick;

  assign tick = en && (cnt_q == '0);

  always_comb begin
    cnt_n = cnt_q;
    if (!en || tick) cnt_n = W'(T_REFI - 1);
    else             cnt_n = cnt_q - 1'b1;
    pend_n = tick || (pend_q && !clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= W'(T_REFI - 1);
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      pend_q <= pend_n;
    end
  end

  assign pend = pend_q;

  // R7: a due refresh is never dropped until it is issued
  a_r7_pend_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !clr) |=> pend_q);

endmodule

// File: rtl/sdram_seq.sv
module sdram_seq #(
  parameter int         ROW_W      = 11,
  parameter int         COL_W      = 9,
  parameter int         DQM_W      = 2,
  parameter int         T_PAUSE    = 10000,
  parameter int         T_RP       = 3,
  parameter int         T_RCD      = 2,
  parameter int         T_RC       = 8,
  parameter int         T_RAS      = 5,
  parameter int         T_WR       = 2,
  parameter int         T_MRD      = 2,
  parameter int         T_REFI     = 1560,
  parameter int         CAS_LAT    = 3,
  parameter logic [2:0] BURST_CODE = 3'd0,
  parameter logic       BURST_ILV  = 1'b0,
  parameter logic       WR_SINGLE  = 1'b1,
  localparam int        ADDR_W     = 1 + ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DQM_W-1:0]  req_wmask,
  output logic              ack,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic              sd_ba,
  output logic [ROW_W-1:0]  sd_a,
  output logic [DQM_W-1:0]  sd_dqm
);
  import sdc_pkg::*;

  localparam int AP_BIT   = 10;
  localparam int ACT_RD   = imax(T_RC, T_RAS + T_RP);
  localparam int ACT_WR   = imax(ACT_RD, T_RCD + T_WR + T_RP);
  localparam int RD_GAP   = ACT_RD - T_RCD;
  localparam int WR_GAP   = ACT_WR - T_RCD;
  localparam int MAXT     = imax(T_PAUSE, imax(ACT_WR, imax(T_RC, T_MRD)));
  localparam int CNT_W    = $clog2(MAXT + 1);
  localparam logic [11:0] MODE = mode_word(BURST_CODE, BURST_ILV, 3'(CAS_LAT), WR_SINGLE);

  // reset synchronizer: asynchronous assert, synchronous release
  logic rs0_q, rs1_q, srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs0_q <= 1'b0;
      rs1_q <= 1'b0;
    end else begin
      rs0_q <= 1'b1;
      rs1_q <= rs0_q;
    end
  end
  assign srst_n = rs1_q;

  seq_state_e        state_q, state_n;
  sd_cmd_e           cmd_q, cmd_n;
  logic [ROW_W-1:0]  a_q, a_n;
  logic              ba_q, ba_n;
  logic [DQM_W-1:0]  dqm_q, dqm_n;
  logic              ack_q, ack_n;
  logic              init2_q, init2_n;
  logic              run_q, run_n;

  logic              ld;
  logic [CNT_W-1:0]  ld_val;
  logic              tmr_done;
  logic              ref_pend, ref_clr;
  logic              acc_ld;

  logic              bank_q, we_q;
  logic [COL_W-1:0]  col_q;
  logic [DQM_W-1:0]  wmask_q;
  logic              late_rd_open;

  sdc_delay #(.W(CNT_W), .RST_VAL(CNT_W'(T_PAUSE - 1))) u_wait (
    .clk(clk), .rst_n(srst_n), .ld(ld), .ld_val(ld_val), .done(tmr_done)
  );

  sdc_ref_tick #(.T_REFI(T_REFI)) u_ref (
    .clk(clk), .rst_n(srst_n), .en(run_q), .clr(ref_clr), .pend(ref_pend)
  );

  // the read output-enable window sits CAS_LAT-2 cycles after READ
  generate
    if (CAS_LAT >= 3) begin : g_cl3
      assign late_rd_open = (cmd_q == CMD_RD);
    end else begin : g_cl2
      assign late_rd_open = 1'b0;
    end
  endgenerate

  always_comb begin
    state_n = state_q;
    cmd_n   = CMD_NOP;
    a_n     = '0;
    ba_n    = 1'b0;
    dqm_n   = '1;
    ack_n   = 1'b0;
    init2_n = init2_q;
    run_n   = run_q;
    ld      = 1'b0;
    ld_val  = '0;
    ref_clr = 1'b0;
    acc_ld  = 1'b0;
    case (state_q)
      ST_PAUSE: begin
        cmd_n = CMD_INH;
        if (tmr_done) begin
          cmd_n         = CMD_PRE;
          a_n[AP_BIT]   = 1'b1;
          ld            = 1'b1;
          ld_val        = CNT_W'(T_RP - 1);
          state_n       = ST_INIT_REF;
        end
      end
      ST_INIT_REF: begin
        if (tmr_done) begin
          cmd_n   = CMD_REF;
          ld      = 1'b1;
          ld_val  = CNT_W'(T_RC - 1);
          init2_n = 1'b1;
          if (init2_q) state_n = ST_INIT_LMR;
        end
      end
      ST_INIT_LMR: begin
        if (tmr_done) begin
          cmd_n   = CMD_LMR;
          ba_n    = MODE[11];
          a_n     = ROW_W'(MODE[10:0]);
          ld      = 1'b1;
          ld_val  = CNT_W'(T_MRD - 1);
          run_n   = 1'b1;
          state_n = ST_IDLE;
        end
      end
      ST_IDLE: begin
        if (tmr_done) begin
          if (ref_pend) begin
            cmd_n   = CMD_REF;
            ref_clr = 1'b1;
            ld      = 1'b1;
            ld_val  = CNT_W'(T_RC - 1);
          end else if (req) begin
            cmd_n   = CMD_ACT;
            ba_n    = req_addr[ADDR_W-1];
            a_n     = req_addr[COL_W +: ROW_W];
            acc_ld  = 1'b1;
            ld      = 1'b1;
            ld_val  = CNT_W'(T_RCD - 1);
            state_n = ST_RW;
          end
        end
      end
      ST_RW: begin
        if (tmr_done) begin
          cmd_n              = we_q ? CMD_WR : CMD_RD;
          a_n[COL_W-1:0]     = col_q;
          a_n[AP_BIT]        = 1'b1;
          ba_n               = bank_q;
          ack_n              = 1'b1;
          ld                 = 1'b1;
          ld_val             = we_q ? CNT_W'(WR_GAP - 1) : CNT_W'(RD_GAP - 1);
          if (we_q)               dqm_n = wmask_q;
          else if (CAS_LAT == 2)  dqm_n = '0;
          state_n            = ST_IDLE;
        end
      end
      default: state_n = ST_PAUSE;
    endcase
    if (late_rd_open) dqm_n = '0;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= ST_PAUSE;
      cmd_q   <= CMD_INH;
      a_q     <= '0;
      ba_q    <= 1'b0;
      dqm_q   <= '1;
      ack_q   <= 1'b0;
      init2_q <= 1'b0;
      run_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      cmd_q   <= cmd_n;
      a_q     <= a_n;
      ba_q    <= ba_n;
      dqm_q   <= dqm_n;
      ack_q   <= ack_n;
      init2_q <= init2_n;
      run_q   <= run_n;
    end
  end

  // request capture, enabled only when ACTIVE is issued
  always_ff @(posedge clk) begin
    if (acc_ld) begin
      bank_q  <= req_addr[ADDR_W-1];
      col_q   <= req_addr[COL_W-1:0];
      we_q    <= req_we;
      wmask_q <= req_wmask;
    end
  end

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign sd_ba  = ba_q;
  assign sd_a   = a_q;
  assign sd_dqm = dqm_q;
  assign ack    = ack_q;

  // ---------------- spacing monitors for the assertions ----------------
  localparam int SAT   = imax(T_RC, T_MRD);
  localparam int SAT_W = $clog2(SAT + 1);
  logic [SAT_W-1:0] since_act_q, since_ref_q, since_lmr_q;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      since_act_q <= SAT_W'(SAT);
      since_ref_q <= SAT_W'(SAT);
      since_lmr_q <= SAT_W'(SAT);
    end else begin
      if (cmd_q == CMD_ACT)                  since_act_q <= SAT_W'(1);
      else if (since_act_q != SAT_W'(SAT))   since_act_q <= since_act_q + 1'b1;
      if (cmd_q == CMD_REF)                  since_ref_q <= SAT_W'(1);
      else if (since_ref_q != SAT_W'(SAT))   since_ref_q <= since_ref_q + 1'b1;
      if (cmd_q == CMD_LMR)                  since_lmr_q <= SAT_W'(1);
      else if (since_lmr_q != SAT_W'(SAT))   since_lmr_q <= since_lmr_q + 1'b1;
    end
  end

  a_r6_act_to_act: assert property (@(posedge clk) disable iff (!srst_n)
    (cmd_q == CMD_ACT) |-> (since_act_q >= SAT_W'(T_RC)));

  a_r12_after_ref: assert property (@(posedge clk) disable iff (!srst_n)
    (cmd_q == CMD_ACT || cmd_q == CMD_REF) |-> (since_ref_q >= SAT_W'(T_RC)));

  a_r12_after_lmr: assert property (@(posedge clk) disable iff (!srst_n)
    (cmd_q == CMD_ACT || cmd_q == CMD_REF) |-> (since_lmr_q >= SAT_W'(T_MRD)));

  a_r5_autopre: assert property (@(posedge clk) disable iff (!srst_n)
    (cmd_q == CMD_RD || cmd_q == CMD_WR) |-> sd_a[AP_BIT]);

  a_r11_ack_on_col: assert property (@(posedge clk) disable iff (!srst_n)
    ack_q |-> (cmd_q == CMD_RD || cmd_q == CMD_WR));

  a_r2_pause_quiet: assert property (@(posedge clk) disable iff (!srst_n)
    (state_q == ST_PAUSE) |-> sd_cs_n);

  a_r10_read_window: assert property (@(posedge clk) disable iff (!srst_n)
    (CAS_LAT >= 3 && $past(cmd_q) == CMD_RD) |-> (sd_dqm == '0));

endmodule

// File: tb/sdram_seq_tb_top.sv
module sdram_seq_tb_top;
  localparam int T_PAUSE = 10000;
  localparam int T_RP    = 3;
  localparam int T_RCD   = 2;
  localparam int T_RC    = 8;
  localparam int T_RAS   = 5;
  localparam int T_WR    = 2;
  localparam int T_REFI  = 1560;
  localparam logic [3:0] C_LMR = 4'b0000, C_REF = 4'b0001, C_PRE = 4'b0010,
                         C_ACT = 4'b0011, C_WR = 4'b0100, C_RD = 4'b0101,
                         C_NOP = 4'b0111, C_INH = 4'b1111;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req, req_we;
  logic [20:0] req_addr;
  logic [1:0]  req_wmask;
  logic        ack, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_ba;
  logic [10:0] sd_a;
  logic [1:0]  sd_dqm;

  int checks = 0, failures = 0, cyc = 0, rel_cyc = 0;
  int dqm_bad = 0, ack_bad = 0;
  logic prev_rd = 1'b0;
  logic done_flag = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sdram_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_wmask(req_wmask), .ack(ack), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_a(sd_a), .sd_dqm(sd_dqm)
  );

  function automatic logic [3:0] bus_cmd();
    return {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  endfunction

  // background invariants for R9, R10, R11
  always @(negedge clk) begin
    if (rst_n) begin
      if (sd_dqm != 2'b11 && !(bus_cmd() == C_WR || prev_rd)) dqm_bad++;
      if (ack != (bus_cmd() == C_WR || bus_cmd() == C_RD)) ack_bad++;
      prev_rd = (bus_cmd() == C_RD);
    end
  end

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic next_cmd(output logic [3:0] c, output int cy);
    int n;
    n = 0;
    forever begin
      @(negedge clk);
      c = bus_cmd();
      if (c != C_NOP && c != C_INH) begin cy = cyc; break; end
      n++;
      if (n > 20000) begin
        chk("R4 no command seen", 0, 1);
        cy = cyc;
        break;
      end
    end
  endtask

  task automatic wait_ref(output int cy);
    logic [3:0] c;
    do next_cmd(c, cy); while (c != C_REF && !done_flag);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; req = 1'b0; req_we = 1'b0; req_addr = '0; req_wmask = '0;
    repeat (4) @(negedge clk);
    chk("R1 cs_n in reset", sd_cs_n, 1);
    chk("R1 dqm in reset", sd_dqm, 2'b11);
    chk("R1 ack in reset", ack, 0);
    rst_n = 1'b1;
    rel_cyc = cyc;
  endtask

  task automatic t_init();
    logic [3:0] c; int cy, prev;
    next_cmd(c, cy);
    chk("R2 pause length ok", (cy - rel_cyc >= T_PAUSE) ? 1 : 0, 1);
    chk("R2 R4 first is PRECHARGE", c, C_PRE);
    chk("R2 A10 all banks", sd_a[10], 1);
    prev = cy;
    next_cmd(c, cy);
    chk("R3 R4 first REFRESH", c, C_REF);
    chk("R3 PRE->REF gap", cy - prev, T_RP);
    prev = cy;
    next_cmd(c, cy);
    chk("R3 second REFRESH", c, C_REF);
    chk("R3 REF->REF gap", cy - prev, T_RC);
    prev = cy;
    next_cmd(c, cy);
    chk("R3 R4 LOAD MODE", c, C_LMR);
    chk("R3 REF->LMR gap", cy - prev, T_RC);
    chk("R3 mode word", {sd_ba, sd_a}, 12'h230);
  endtask

  task automatic t_write();
    logic [3:0] c; int r, cy, act_cy;
    wait_ref(r);
    req = 1'b1; req_we = 1'b1; req_addr = {1'b1, 11'h5A5, 9'h1C3}; req_wmask = 2'b01;
    next_cmd(c, act_cy);
    chk("R4 R5 ACTIVE code", c, C_ACT);
    chk("R12 REF->ACT gap", act_cy - r, T_RC);
    chk("R5 ACT row", sd_a, 11'h5A5);
    chk("R5 ACT bank", sd_ba, 1);
    next_cmd(c, cy);
    req = 1'b0;
    chk("R4 WRITE code", c, C_WR);
    chk("R5 ACT->WR gap", cy - act_cy, T_RCD);
    chk("R5 WR column+A10", sd_a, 11'h5C3);
    chk("R5 WR bank", sd_ba, 1);
    chk("R9 WR dqm = mask", sd_dqm, 2'b01);
    chk("R11 ack on WR", ack, 1);
    @(negedge clk);
    chk("R9 dqm after WR", sd_dqm, 2'b11);
    chk("R11 ack single cycle", ack, 0);
  endtask

  task automatic t_read();
    logic [3:0] c; int r, cy, act_cy;
    wait_ref(r);
    req = 1'b1; req_we = 1'b0; req_addr = {1'b0, 11'h7FF, 9'h000}; req_wmask = 2'b11;
    next_cmd(c, act_cy);
    chk("R5 ACT row all ones", sd_a, 11'h7FF);
    chk("R5 ACT bank 0", sd_ba, 0);
    next_cmd(c, cy);
    req = 1'b0;
    chk("R4 READ code", c, C_RD);
    chk("R5 RD column+A10", sd_a, 11'h400);
    chk("R10 dqm high in READ cycle", sd_dqm, 2'b11);
    chk("R11 ack on RD", ack, 1);
    @(negedge clk);
    chk("R10 dqm low one after READ", sd_dqm, 2'b00);
    @(negedge clk);
    chk("R10 dqm high again", sd_dqm, 2'b11);
  endtask

  task automatic t_back_to_back();
    logic [3:0] c; int r, cy, a1, a2;
    wait_ref(r);
    req = 1'b1; req_we = 1'b1; req_addr = {1'b0, 11'h123, 9'h0FF}; req_wmask = 2'b10;
    next_cmd(c, a1);
    next_cmd(c, cy);
    chk("R9 WR mask 10", sd_dqm, 2'b10);
    req_we = 1'b0; req_addr = {1'b1, 11'h321, 9'h001};
    next_cmd(c, a2);
    chk("R6 ACT after write gap", a2 - a1,
        (T_RCD + T_WR + T_RP > ((T_RC > T_RAS + T_RP) ? T_RC : T_RAS + T_RP)) ?
        T_RCD + T_WR + T_RP : ((T_RC > T_RAS + T_RP) ? T_RC : T_RAS + T_RP));
    chk("R5 second ACT row", sd_a, 11'h321);
    next_cmd(c, cy);
    req_addr = {1'b0, 11'h456, 9'h002};
    chk("R4 second is READ", c, C_RD);
    next_cmd(c, cy);
    req = 1'b0;
    chk("R6 ACT after read gap", cy - a2, (T_RC > T_RAS + T_RP) ? T_RC : T_RAS + T_RP);
    next_cmd(c, cy);
    chk("R5 READ of third request", c, C_RD);
  endtask

  task automatic t_refresh();
    logic [3:0] c; int r1, r2, cy;
    wait_ref(r1);
    next_cmd(c, r2);
    chk("R7 idle refresh code", c, C_REF);
    chk("R7 refresh period", r2 - r1, T_REFI);
    while (cyc < r2 + T_REFI - 4) @(negedge clk);
    req = 1'b1; req_we = 1'b0; req_addr = {1'b1, 11'h0AA, 9'h055};
    next_cmd(c, cy);
    chk("R5 ACT before due refresh", c, C_ACT);
    next_cmd(c, cy);
    chk("R5 READ before due refresh", c, C_RD);
    req_addr = {1'b0, 11'h055, 9'h0AA};
    next_cmd(c, r1);
    chk("R8 refresh wins over request", c, C_REF);
    next_cmd(c, cy);
    req = 1'b0;
    chk("R8 request served after refresh", c, C_ACT);
    chk("R12 REF->ACT gap with waiting request", cy - r1, T_RC);
    next_cmd(c, cy);
    chk("R5 READ after refresh", c, C_RD);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk("R4 watchdog expired", 0, 1);
    summary();
  end

  initial begin
    t_reset();
    t_init();
    t_write();
    t_read();
    t_back_to_back();
    t_refresh();
    repeat (4) @(negedge clk);
    chk("R9 R10 dqm outside windows", dqm_bad, 0);
    chk("R11 ack only with column cmd", ack_bad, 0);
    summary();
  end
endmodule